// File: doc/BRIEF.md
# NAND Address Sequencer

This block turns one addressing request into the ordered stream of address bytes that a NAND flash device expects after a command. A request names whether a column is wanted, whether a row (page) address is wanted, the 24-bit page number, the page-size mode and the device capacity in MiB. The block works out how many column and row bytes the device needs, then presents the bytes one at a time to a downstream NAND bus interface over a valid/ready handshake. The last byte of the series carries a last flag.

Column bytes are always zero, because every transfer begins at the start of a page. Row bytes follow, least significant byte first. The count of row bytes grows to three on large devices, and the capacity at which that happens depends on the page-size mode. A one-clock start pulse launches a series, and a one-clock done pulse reports its end. Bus timing and command bytes belong to the downstream interface.

Top module: `nand_addr_seq`

## Requirements
- R1: With the column flag set, the series opens with column bytes of value 0x00: one byte when `big_page_i` is 0 (512-byte pages), two bytes when `big_page_i` is 1 (2 KiB pages). With the column flag clear, no column byte is sent.
- R2: Row bytes follow any column bytes in this order: page bits 7:0, then page bits 15:8, then (when required) page bits 23:16.
- R3: When `big_page_i` is 1, the third row byte is sent only when `cap_mib_i` is 256 or more.
- R4: When `big_page_i` is 0, the third row byte is sent only when `cap_mib_i` is 64 or more.
- R5: With the row flag clear, the final column byte carries `byte_last_o`.
- R6: With the row flag set, `byte_last_o` is high only on the final row byte, never on a column byte.
- R7: All request inputs are captured on the start pulse. Later changes to them do not alter the series in progress.
- R8: A start pulse that arrives while a series is in progress is ignored. It neither restarts nor extends the series, and no second series follows.
- R9: While `byte_valid_o` is high and `byte_ready_i` is low, `byte_valid_o`, `byte_data_o` and `byte_last_o` hold their values into the next cycle.
- R10: `done_o` rises in the cycle after the handshake on the last byte and stays high for exactly one cycle.
- R11: A request with both flags clear raises `done_o` in the cycle after the start pulse and sends no byte.
- R12: During and after reset, `byte_valid_o`, `byte_last_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that launches a series |
| col_req_i | input | 1 | Column bytes wanted |
| row_req_i | input | 1 | Row bytes wanted |
| row_addr_i | input | 24 | Page number |
| big_page_i | input | 1 | 1 = 2 KiB page mode, 0 = 512-byte page mode |
| cap_mib_i | input | 16 | Device capacity in MiB |
| byte_ready_i | input | 1 | Downstream accepts the current byte |
| byte_valid_o | output | 1 | A byte is on offer |
| byte_data_o | output | 8 | Address byte |
| byte_last_o | output | 1 | Current byte ends the series |
| done_o | output | 1 | One-cycle end-of-series pulse |

## Verification
The hardest situation to reach from the ports is a second start pulse that lands in the middle of a stalled series, while the request inputs already hold different values. Each directed scenario overwrites every request input with its complement right after the start pulse. The restart scenario then pulses start again with yet another request while ready is held off. The bench checks that the original byte list arrives intact with a single done pulse, and that no further series follows. Capacity values just below and at both thresholds, combined with irregular ready patterns, cover the byte counts and the hold behaviour under back-pressure.

// File: rtl/nand_addr_pkg.sv
// Package: shared constants and types for the NAND address sequencer.
// Assumes at most two column bytes and three row bytes per series.
package nand_addr_pkg;

    localparam int MAX_COL_BYTES = 2;
    localparam int MAX_ROW_BYTES = 3;
    localparam int CNT_W         = $clog2(MAX_COL_BYTES + MAX_ROW_BYTES + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    typedef struct packed {
        cnt_t n_col;
        cnt_t n_total;
    } plan_t;

endpackage

// File: rtl/nand_addr_plan.sv
// Module: nand_addr_plan
// Works out, combinationally, how many column bytes and how many bytes
// in total a request needs. The result depends on the page-size mode and
// on the capacity thresholds.
// Assumes the capacity input is in MiB and the thresholds use the same unit.
module nand_addr_plan
    import nand_addr_pkg::*;
#(
    parameter int CAP_W          = 16,
    parameter int BIG_THRESH_MIB = 256,
    parameter int SML_THRESH_MIB = 64
) (
    input  logic             col_req_i,
    input  logic             row_req_i,
    input  logic             big_page_i,
    input  logic [CAP_W-1:0] cap_mib_i,
    output plan_t            plan_o
);

    localparam logic [CAP_W-1:0] BIG_LIM = CAP_W'(BIG_THRESH_MIB);
    localparam logic [CAP_W-1:0] SML_LIM = CAP_W'(SML_THRESH_MIB);

    logic third_row;
    cnt_t n_col;
    cnt_t n_row;

    // Decide whether the device is large enough to need a third row byte.
    always_comb begin
        if (big_page_i) third_row = (cap_mib_i >= BIG_LIM);
        else            third_row = (cap_mib_i >= SML_LIM);
    end

    // Count column and row bytes for the request.
    always_comb begin
        n_col = '0;
        n_row = '0;
        if (col_req_i) n_col = big_page_i ? cnt_t'(2) : cnt_t'(1);
        if (row_req_i) n_row = third_row  ? cnt_t'(3) : cnt_t'(2);
        plan_o.n_col   = n_col;
        plan_o.n_total = n_col + n_row;
    end

    // The byte total never exceeds the buffer layout (R1..R4).
    always_comb begin
        assert_total_bound_R1: assert (plan_o.n_total <= cnt_t'(MAX_COL_BYTES + MAX_ROW_BYTES))
            else $error("byte total out of range");
    end

endmodule

// File: rtl/nand_addr_ctrl.sv
// Module: nand_addr_ctrl
// Sequencer state machine. It accepts a start only when idle, latches the
// byte plan, steps a byte index on each accepted handshake and pulses done
// after the last byte.
// Assumes the downstream side keeps ready meaningful only while valid is high.
module nand_addr_ctrl
    import nand_addr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  plan_t plan_i,
    input  logic  ready_i,
    output logic  load_o,
    output logic  valid_o,
    output logic  last_o,
    output logic  done_o,
    output cnt_t  idx_o,
    output cnt_t  ncol_o
);

    seq_state_t state_q;
    cnt_t       idx_q;
    cnt_t       ncol_q;
    cnt_t       ntot_q;
    logic       at_end;

    assign load_o = start_i && (state_q == ST_IDLE);
    assign at_end = (idx_q == cnt_t'(ntot_q - cnt_t'(1)));

    // Advance the state, capture the plan on an accepted start, step the index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            ncol_q  <= '0;
            ntot_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        ncol_q  <= plan_i.n_col;
                        ntot_q  <= plan_i.n_total;
                        idx_q   <= '0;
                        state_q <= (plan_i.n_total == '0) ? ST_DONE : ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (ready_i) begin
                        if (at_end) state_q <= ST_DONE;
                        else        idx_q   <= idx_q + cnt_t'(1);
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the handshake and completion outputs from the state.
    always_comb begin
        valid_o = (state_q == ST_SEND);
        last_o  = valid_o && at_end;
        done_o  = (state_q == ST_DONE);
        idx_o   = idx_q;
        ncol_o  = ncol_q;
    end

    // A stalled byte keeps its slot.
    assert_hold_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(idx_o)));

    // Done follows the last accepted byte.
    assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && last_o) |=> done_o);

    // Done lasts a single cycle.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // A start during a series changes neither the index nor the plan.
    assert_ignore_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i && start_i) |=> ($stable(idx_o) && $stable(ncol_o)));

endmodule

// File: rtl/nand_addr_mux.sv
// Module: nand_addr_mux
// Holds the captured page number and selects the byte for the current
// index: zero for column slots, then the row bytes from least significant up.
// Assumes ROW_W is a multiple of 8.
module nand_addr_mux
    import nand_addr_pkg::*;
#(
    parameter int ROW_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [ROW_W-1:0] row_addr_i,
    input  cnt_t             idx_i,
    input  cnt_t             ncol_i,
    output logic [7:0]       data_o
);

    localparam int ROW_BYTES = ROW_W / 8;

    logic [ROW_W-1:0] row_q;
    logic [7:0]       row_byte [ROW_BYTES];
    cnt_t             row_idx;
    logic             in_col;

    // Capture the page number when a series is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      row_q <= '0;
        else if (load_i) row_q <= row_addr_i;
    end

    // Slice the page number into bytes, least significant first.
    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_slice
        assign row_byte[g] = row_q[8*g +: 8];
    end

    // Choose a zero for column slots or the matching row byte.
    always_comb begin
        in_col  = (idx_i < ncol_i);
        row_idx = idx_i - ncol_i;
        data_o  = 8'h00;
        if (!in_col) begin
            for (int k = 0; k < ROW_BYTES; k++) begin
                if (row_idx == cnt_t'(k)) data_o = row_byte[k];
            end
        end
    end

endmodule

// File: rtl/nand_addr_seq.sv
// Module: nand_addr_seq (top)
// Emits the column and row address bytes for one NAND access over a
// valid/ready handshake, with a last flag and a done pulse.
// Assumes start_i is a single-cycle pulse; starts while busy are dropped.
module nand_addr_seq
    import nand_addr_pkg::*;
#(
    parameter int ROW_W          = 24,
    parameter int CAP_W          = 16,
    parameter int BIG_THRESH_MIB = 256,
    parameter int SML_THRESH_MIB = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             col_req_i,
    input  logic             row_req_i,
    input  logic [ROW_W-1:0] row_addr_i,
    input  logic             big_page_i,
    input  logic [CAP_W-1:0] cap_mib_i,
    input  logic             byte_ready_i,
    output logic             byte_valid_o,
    output logic [7:0]       byte_data_o,
    output logic             byte_last_o,
    output logic             done_o
);

    plan_t plan;
    logic  load;
    cnt_t  idx;
    cnt_t  ncol;

    nand_addr_plan #(
        .CAP_W          (CAP_W),
        .BIG_THRESH_MIB (BIG_THRESH_MIB),
        .SML_THRESH_MIB (SML_THRESH_MIB)
    ) u_plan (
        .col_req_i  (col_req_i),
        .row_req_i  (row_req_i),
        .big_page_i (big_page_i),
        .cap_mib_i  (cap_mib_i),
        .plan_o     (plan)
    );

    nand_addr_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .plan_i  (plan),
        .ready_i (byte_ready_i),
        .load_o  (load),
        .valid_o (byte_valid_o),
        .last_o  (byte_last_o),
        .done_o  (done_o),
        .idx_o   (idx),
        .ncol_o  (ncol)
    );

    nand_addr_mux #(
        .ROW_W (ROW_W)
    ) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .row_addr_i (row_addr_i),
        .idx_i      (idx),
        .ncol_i     (ncol),
        .data_o     (byte_data_o)
    );

    // Offered data stays put under back-pressure.
    assert_data_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && !byte_ready_i) |=> $stable(byte_data_o) && $stable(byte_last_o));

    // Completion and an offered byte never coincide.
    assert_done_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !byte_valid_o);

    // The cycle after reset is quiet.
    assert_reset_quiet_R12: assert property (@(posedge clk)
        !rst_n |=> (!byte_valid_o && !done_o));

endmodule

// File: tb/sim_nand_addr_seq.sv
module sim_nand_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        col_req;
    logic        row_req;
    logic [23:0] row_addr;
    logic        big_page;
    logic [15:0] cap_mib;
    logic        ready;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        byte_last;
    logic        done;

    int n_chk  = 0;
    int n_bad  = 0;
    bit closed = 1'b0;

    always #5 clk = ~clk;

    nand_addr_seq u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .col_req_i    (col_req),
        .row_req_i    (row_req),
        .row_addr_i   (row_addr),
        .big_page_i   (big_page),
        .cap_mib_i    (cap_mib),
        .byte_ready_i (ready),
        .byte_valid_o (byte_valid),
        .byte_data_o  (byte_data),
        .byte_last_o  (byte_last),
        .done_o       (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One full series: drive start, scramble inputs (R7), optionally restart (R8),
    // collect bytes, then compare with the expected list.
    task automatic run_case(input string req, input logic c, input logic r,
                            input logic b, input logic [15:0] cap,
                            input logic [23:0] a, input logic [7:0] rpat,
                            input int inj);
        logic [7:0] exp_b [0:7];
        logic [7:0] got_b [0:7];
        int   ne, ncol, ng, last_pos, last_cnt, done_cnt, bad_hold, quiet_bad;
        bit   third, exp_done, done_ok, fin, prev_stall;
        logic [7:0] prev_data;
        logic       prev_last;
        ncol  = c ? (b ? 2 : 1) : 0;
        third = b ? (cap >= 16'd256) : (cap >= 16'd64);
        ne    = ncol;
        for (int i = 0; i < 8; i++) exp_b[i] = 8'h00;
        if (r) begin
            exp_b[ne] = a[7:0];   ne++;
            exp_b[ne] = a[15:8];  ne++;
            if (third) begin exp_b[ne] = a[23:16]; ne++; end
        end
        ng = 0; last_pos = -1; last_cnt = 0; done_cnt = 0; bad_hold = 0;
        done_ok = 0; fin = 0; prev_stall = 0; prev_data = 0; prev_last = 0;
        @(negedge clk);
        col_req = c; row_req = r; big_page = b; cap_mib = cap; row_addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R7: inputs change right after capture
        col_req = ~c; row_req = ~r; big_page = ~b; cap_mib = ~cap; row_addr = ~a;
        exp_done = (ne == 0);
        for (int cyc = 0; cyc < 64 && !fin; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (cyc == inj) begin
                start = 1'b1; col_req = 1'b1; row_req = 1'b1; big_page = 1'b1;
                cap_mib = 16'hFFFF; row_addr = 24'hC3C3C3;
            end else begin
                start = 1'b0;
            end
            if (done) begin
                done_cnt++;
                if (exp_done) done_ok = 1;
                fin = 1;
            end
            exp_done = 0;
            if (prev_stall && (!byte_valid || byte_data != prev_data || byte_last != prev_last))
                bad_hold++;
            ready = rpat[cyc % 8];
            if (byte_valid && ready) begin
                if (ng < 8) got_b[ng] = byte_data;
                if (byte_last) begin last_pos = ng; last_cnt++; exp_done = 1; end
                ng++;
            end
            prev_stall = byte_valid && !ready;
            prev_data  = byte_data;
            prev_last  = byte_last;
        end
        start = 1'b0;
        ready = 1'b1;
        quiet_bad = 0;
        for (int q = 0; q < 6; q++) begin
            @(negedge clk);
            if (byte_valid || done) quiet_bad++;
        end
        ready = 1'b0;
        check(ng == ne, req, "byte count", ng, ne);
        for (int i = 0; i < ne && i < ng; i++)
            check(got_b[i] == exp_b[i], req, $sformatf("byte %0d", i), got_b[i], exp_b[i]);
        if (ne > 0) begin
            check(last_pos == ne - 1, req, "R5/R6 last position", last_pos, ne - 1);
            check(last_cnt == 1, req, "R6 last count", last_cnt, 1);
        end
        check(done_ok && done_cnt == 1, req, "R10/R11 done timing", done_cnt, 1);
        check(bad_hold == 0, req, "R9 hold under stall", bad_hold, 0);
        check(quiet_bad == 0, req, "R8/R10 quiet after done", quiet_bad, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; start = 0; col_req = 0; row_req = 0; row_addr = 0;
        big_page = 0; cap_mib = 0; ready = 0;
        repeat (3) @(negedge clk);
        check(!byte_valid, "R12", "valid in reset", byte_valid, 0);
        check(!done, "R12", "done in reset", done, 0);
        check(!byte_last, "R12", "last in reset", byte_last, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!byte_valid && !done, "R12", "quiet after reset", {byte_valid, done}, 0);
    endtask

    task automatic t_col_only;
        run_case("R1_R5_small", 1, 0, 0, 16'd128, 24'h123456, 8'hFF, -1);
        run_case("R1_R5_big", 1, 0, 1, 16'd1024, 24'h654321, 8'b0110_1101, -1);
    endtask

    task automatic t_small_page;
        run_case("R4_R2_below", 1, 1, 0, 16'd63, 24'hA1B2C3, 8'hFF, -1);
        run_case("R4_R2_at", 1, 1, 0, 16'd64, 24'hA1B2C3, 8'b1010_1010, -1);
    endtask

    task automatic t_big_page;
        run_case("R3_R6_below", 1, 1, 1, 16'd255, 24'h0F1E2D, 8'b1100_1001, -1);
        run_case("R3_R6_at", 1, 1, 1, 16'd256, 24'h0F1E2D, 8'hFF, -1);
    endtask

    task automatic t_row_only;
        run_case("R6_R2_rowonly", 0, 1, 1, 16'd512, 24'h89ABCD, 8'b0001_0001, -1);
    endtask

    task automatic t_empty;
        run_case("R11_empty", 0, 0, 1, 16'd512, 24'hFFFFFF, 8'hFF, -1);
    endtask

    task automatic t_restart;
        run_case("R8_R7_restart", 1, 1, 0, 16'd32, 24'h00BEEF, 8'b1000_0000, 2);
    endtask

    initial begin
        t_reset;
        t_col_only;
        t_small_page;
        t_big_page;
        t_row_only;
        t_empty;
        t_restart;
        if (!closed) begin
            closed = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!closed) begin
            closed = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule